// File: doc/BRIEF.md
# Multi-slice edge event timestamper

The block watches `NUM_SLICES` groups of 32 input lines, each group called a slice. Line `b` of slice `s` is global line `s*32 + b`. A per-line mask selects which lines take part. Whenever the masked value of a slice differs from the value last reported for it, the block stores one pending record for that slice. The record holds the free-running 64-bit timestamp, the slice index, the previously reported masked value and the new masked value. Software finds the lines that changed by XORing the two value fields. Several lines that change in the same sample share one record.

A free-running counter advances once every `TICK_DIV` clock cycles. With a 125 MHz clock and the default divider of 4, that is one tick per 32 ns. Records leave through a push-side valid/ready handshake towards an external queue. When several slices hold records, the lowest-numbered slice is offered first, and an offered record stays on the port until it is accepted. If a slice changes again while its record is still waiting, the sticky overflow flag is set. The global capture enable stops new records from being formed, but records that are already pending still drain.

Top module: `slice_event_stamper`

## Requirements
- R1: While `rst_ni` is low and right after reset: `evt_valid_o` = 0, `ovf_o` = 0, the timestamp counter is 0, and the stored reported value of every slice is 0.
- R2: The timestamp counter starts at 0 when reset is released and advances by 1 every `TICK_DIV` clock edges. A record's `evt_ts_o` is the counter value in the cycle whose closing edge detected the change, so two detections 16 edges apart differ by exactly 4 with `TICK_DIV` = 4.
- R3: Only lines whose mask bit is 1 take part. A masked-off line reads as 0 in both value fields, and toggling it alone forms no record.
- R4: Slice `s` uses bits `[s*32+31 : s*32]` of `lines_i` and `mask_i`, and `evt_slice_o` carries `s` as an unsigned number.
- R5: Lines of one slice that change at the same edge produce a single record, with each changed line shown as a 1 in `evt_prev_o ^ evt_curr_o`.
- R6: `evt_prev_o` equals the `evt_curr_o` of the last accepted record for that slice, or 0 if no record has been accepted since reset.
- R7: While `cap_en_i` = 0 no record is formed, and records already pending are still offered. When capture resumes, a masked value that differs from the last reported value forms a record at the next edge.
- R8: Among pending slices, the lowest index is offered first. Slices that detected a change at the same edge carry the same timestamp.
- R9: While `evt_valid_o` = 1 and `evt_ready_i` = 0, the valid signal and all record fields hold stable. Each record is delivered exactly once, at the edge where valid and ready are both 1.
- R10: `ovf_o` becomes 1 after an edge at which a slice whose record is pending and not being accepted has a masked value different from its pending `evt_curr_o` (with capture enabled). The pending record keeps its first capture, and `ovf_o` stays 1 until reset.
- R11: If a slice's record is accepted at an edge where its masked value already differs from the accepted current value, a new record for that slice is formed at that same edge. No overflow is flagged in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_en_i | input | 1 | Global capture enable |
| lines_i | input | NUM_SLICES*32 | Synchronised input lines, slice `s` at bits `s*32 +: 32` |
| mask_i | input | NUM_SLICES*32 | Per-line enable, same layout as `lines_i` |
| evt_valid_o | output | 1 | A record is offered |
| evt_ready_i | input | 1 | Downstream queue accepts the offered record |
| evt_ts_o | output | 64 | Timestamp of the record |
| evt_slice_o | output | max(1,clog2(NUM_SLICES)) | Slice index of the record |
| evt_prev_o | output | 32 | Previously reported masked value of the slice |
| evt_curr_o | output | 32 | New masked value of the slice |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is acceptance of a slice's record and a fresh change on that same slice, which tests re-arming against overflow. The second pair is detection on several slices at one edge while the output is stalled, which tests ordering, shared timestamps and holding the offered record. Directed sequences flip a line exactly on the acceptance edge, and flip lines in slices 0 and 2 together with ready held low. Long random runs with sparse line flips, random ready and occasional mask and enable changes are judged every cycle against a bench model built from the requirements.

// File: rtl/ses_pkg.sv
package ses_pkg;
  localparam int unsigned SLICE_LINES = 32;
  localparam int unsigned TS_W        = 64;
endpackage

// File: rtl/ses_ts_counter.sv
module ses_ts_counter
  import ses_pkg::*;
#(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] ts_o
);
  logic tick;

  generate
    if (TICK_DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_q;
      assign tick = (div_q == DW'(TICK_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + DW'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ts_o <= '0;
    else if (tick) ts_o <= ts_o + TS_W'(1);
  end
endmodule

// File: rtl/ses_slice_tracker.sv
module ses_slice_tracker
  import ses_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic [SLICE_LINES-1:0] lines_i,
  input  logic [SLICE_LINES-1:0] mask_i,
  input  logic [TS_W-1:0]        ts_i,
  input  logic                   pop_i,
  output logic                   pend_o,
  output logic [TS_W-1:0]        pend_ts_o,
  output logic [SLICE_LINES-1:0] pend_cur_o,
  output logic [SLICE_LINES-1:0] prev_o,
  output logic                   ovf_o
);
  logic [SLICE_LINES-1:0] cur, base;
  logic                   det;

  assign cur   = lines_i & mask_i;
  // compare against what is pending if anything, else what was last reported
  assign base  = pend_o ? pend_cur_o : prev_o;
  assign det   = en_i && (cur != base);
  assign ovf_o = pend_o && !pop_i && det;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o     <= 1'b0;
      pend_ts_o  <= '0;
      pend_cur_o <= '0;
      prev_o     <= '0;
    end else if (pend_o && pop_i) begin
      prev_o <= pend_cur_o;
      if (det) begin
        pend_ts_o  <= ts_i;
        pend_cur_o <= cur;
      end else begin
        pend_o <= 1'b0;
      end
    end else if (!pend_o && det) begin
      pend_o     <= 1'b1;
      pend_ts_o  <= ts_i;
      pend_cur_o <= cur;
    end
  end
endmodule

// File: rtl/ses_low_first_arb.sv
module ses_low_first_arb #(
  parameter int unsigned N  = 3,
  parameter int unsigned IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          ready_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic          lock_q;
  logic [IW-1:0] lidx_q, low_idx;

  always_comb begin
    low_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) low_idx = IW'(i);
    end
  end

  assign any_o = |req_i;
  // a stalled offer keeps its slice so the record stays stable
  assign idx_o = lock_q ? lidx_q : low_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      lidx_q <= '0;
    end else begin
      lock_q <= any_o && !ready_i;
      lidx_q <= idx_o;
    end
  end
endmodule

// File: rtl/slice_event_stamper.sv
module slice_event_stamper
  import ses_pkg::*;
#(
  parameter int unsigned NUM_SLICES = 3,
  parameter int unsigned TICK_DIV   = 4,
  localparam int unsigned IW   = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
  localparam int unsigned BUSW = NUM_SLICES * SLICE_LINES
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cap_en_i,
  input  logic [BUSW-1:0]        lines_i,
  input  logic [BUSW-1:0]        mask_i,
  output logic                   evt_valid_o,
  input  logic                   evt_ready_i,
  output logic [TS_W-1:0]        evt_ts_o,
  output logic [IW-1:0]          evt_slice_o,
  output logic [SLICE_LINES-1:0] evt_prev_o,
  output logic [SLICE_LINES-1:0] evt_curr_o,
  output logic                   ovf_o
);
  logic [TS_W-1:0]        ts_now;
  logic [NUM_SLICES-1:0]  pend, pop, ovf_hit;
  logic [TS_W-1:0]        pend_ts  [NUM_SLICES];
  logic [SLICE_LINES-1:0] pend_cur [NUM_SLICES];
  logic [SLICE_LINES-1:0] prev     [NUM_SLICES];
  logic [IW-1:0]          sel;
  logic                   any;
  logic                   ovf_q;

  ses_ts_counter #(.TICK_DIV(TICK_DIV)) u_ts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ts_o  (ts_now)
  );

  ses_low_first_arb #(.N(NUM_SLICES), .IW(IW)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (pend),
    .ready_i(evt_ready_i),
    .idx_o  (sel),
    .any_o  (any)
  );

  generate
    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      assign pop[s] = evt_ready_i && any && (sel == IW'(s));
      ses_slice_tracker u_trk (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (cap_en_i),
        .lines_i   (lines_i[s*SLICE_LINES +: SLICE_LINES]),
        .mask_i    (mask_i[s*SLICE_LINES +: SLICE_LINES]),
        .ts_i      (ts_now),
        .pop_i     (pop[s]),
        .pend_o    (pend[s]),
        .pend_ts_o (pend_ts[s]),
        .pend_cur_o(pend_cur[s]),
        .prev_o    (prev[s]),
        .ovf_o     (ovf_hit[s])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= ovf_q | (|ovf_hit);
  end

  assign evt_valid_o = any;
  assign evt_slice_o = sel;
  assign evt_ts_o    = pend_ts[sel];
  assign evt_prev_o  = prev[sel];
  assign evt_curr_o  = pend_cur[sel];
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/ses_event_chk.sv
module ses_event_chk
  import ses_pkg::*;
#(
  parameter int unsigned NUM_SLICES = 3,
  localparam int unsigned IW = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cap_en_i,
  input logic                   evt_valid_o,
  input logic                   evt_ready_i,
  input logic [TS_W-1:0]        evt_ts_o,
  input logic [IW-1:0]          evt_slice_o,
  input logic [SLICE_LINES-1:0] evt_prev_o,
  input logic [SLICE_LINES-1:0] evt_curr_o,
  input logic                   ovf_o
);
  a_r9_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && !evt_ready_i) |=> (evt_valid_o && $stable(evt_ts_o) &&
      $stable(evt_slice_o) && $stable(evt_prev_o) && $stable(evt_curr_o)));

  a_r10_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  a_r5_record_differs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> (evt_prev_o != evt_curr_o));

  a_r4_slice_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> (int'(evt_slice_o) < int'(NUM_SLICES)));

  a_r7_no_capture_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_en_i && !evt_valid_o) |=> !evt_valid_o);
endmodule

bind slice_event_stamper ses_event_chk #(.NUM_SLICES(NUM_SLICES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cap_en_i   (cap_en_i),
  .evt_valid_o(evt_valid_o),
  .evt_ready_i(evt_ready_i),
  .evt_ts_o   (evt_ts_o),
  .evt_slice_o(evt_slice_o),
  .evt_prev_o (evt_prev_o),
  .evt_curr_o (evt_curr_o),
  .ovf_o      (ovf_o)
);

// File: tb/sim_slice_event_stamper.sv
`timescale 1ns/1ps
module sim_slice_event_stamper;
  localparam int N   = 3;
  localparam int DIV = 4;
  localparam int BW  = N * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cap_en = 1'b1;
  logic          ready = 1'b1;
  logic [BW-1:0] lines = '0;
  logic [BW-1:0] mask = '1;
  logic          evt_valid;
  logic [63:0]   evt_ts;
  logic [1:0]    evt_slice;
  logic [31:0]   evt_prev, evt_curr;
  logic          ovf;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  slice_event_stamper #(.NUM_SLICES(N), .TICK_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cap_en_i(cap_en), .lines_i(lines), .mask_i(mask),
    .evt_valid_o(evt_valid), .evt_ready_i(ready), .evt_ts_o(evt_ts),
    .evt_slice_o(evt_slice), .evt_prev_o(evt_prev), .evt_curr_o(evt_curr), .ovf_o(ovf)
  );

  // reference model from the requirements
  bit          m_pend [N];
  logic [63:0] m_pts  [N];
  logic [31:0] m_prev [N];
  logic [31:0] m_pcur [N];
  bit          m_lock;
  int          m_lidx;
  logic [63:0] m_ts;
  int          m_div;
  bit          m_ovf;

  function automatic int m_sel();
    int r = 0;
    if (m_lock) return m_lidx;
    for (int i = N - 1; i >= 0; i--) if (m_pend[i]) r = i;
    return r;
  endfunction

  function automatic bit m_any();
    bit a = 0;
    for (int i = 0; i < N; i++) a |= m_pend[i];
    return a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N; s++) begin
        m_pend[s] = 0; m_pts[s] = '0; m_prev[s] = '0; m_pcur[s] = '0;
      end
      m_lock = 0; m_lidx = 0; m_ts = '0; m_div = 0; m_ovf = 0;
    end else begin
      int  sel;
      bit  any, pop, det;
      logic [31:0] cur, base;
      sel = m_sel();
      any = m_any();
      pop = any && ready;
      for (int s = 0; s < N; s++) begin
        cur  = lines[s*32 +: 32] & mask[s*32 +: 32];
        base = m_pend[s] ? m_pcur[s] : m_prev[s];
        det  = cap_en && (cur != base);
        if (m_pend[s] && pop && sel == s) begin
          m_prev[s] = m_pcur[s];
          if (det) begin m_pts[s] = m_ts; m_pcur[s] = cur; end
          else m_pend[s] = 0;
        end else if (m_pend[s]) begin
          if (det) m_ovf = 1;
        end else if (det) begin
          m_pend[s] = 1; m_pts[s] = m_ts; m_pcur[s] = cur;
        end
      end
      m_lock = any && !ready;
      m_lidx = sel;
      if (m_div == DIV - 1) begin m_div = 0; m_ts = m_ts + 64'd1; end
      else m_div = m_div + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int s;
    bit v;
    v = m_any();
    s = m_sel();
    chk("R8/R9 valid", 64'(evt_valid), 64'(v));
    if (v) begin
      chk("R2 timestamp", evt_ts, m_pts[s]);
      chk("R4 slice", 64'(evt_slice), 64'(s));
      chk("R6 prev", 64'(evt_prev), 64'(m_prev[s]));
      chk("R3 curr", 64'(evt_curr), 64'(m_pcur[s]));
    end
    chk("R10 ovf", 64'(ovf), 64'(m_ovf));
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic flip(input int b);
    lines[b] = ~lines[b];
  endtask

  task automatic drain();
    ready = 1'b1;
    repeat (8) tick();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    logic [63:0] t0, ta;
    repeat (3) begin
      @(negedge clk);
      chk("R1 valid in reset", 64'(evt_valid), 64'd0);
      chk("R1 ovf in reset", 64'(ovf), 64'd0);
    end
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 idle after reset", 64'(evt_valid), 64'd0);

    // R5: two lines of slice 1 at one edge, one record
    ready = 1'b0;
    flip(32); flip(37);
    tick();
    chk("R5 one record", 64'(evt_valid), 64'd1);
    chk("R4 slice 1", 64'(evt_slice), 64'd1);
    chk("R5 xor", 64'(evt_prev ^ evt_curr), 64'h21);
    t0 = evt_ts;
    tick(); tick();
    chk("R9 held valid", 64'(evt_valid), 64'd1);
    chk("R9 held ts", evt_ts, t0);
    drain();

    // R8: slices 0 and 2 at one edge, stalled
    ready = 1'b0;
    flip(3); flip(71);
    tick();
    chk("R8 lowest first", 64'(evt_slice), 64'd0);
    chk("R8 xor slice0", 64'(evt_prev ^ evt_curr), 64'h8);
    t0 = evt_ts;
    ready = 1'b1;
    tick();
    chk("R8 then slice 2", 64'(evt_slice), 64'd2);
    chk("R8 same ts", evt_ts, t0);
    chk("R8 xor slice2", 64'(evt_prev ^ evt_curr), 64'h80);
    tick();
    chk("R9 delivered once", 64'(evt_valid), 64'd0);
    drain();

    // R3: masked line ignored
    mask[36] = 1'b0;
    flip(36);
    repeat (3) tick();
    chk("R3 masked toggle quiet", 64'(evt_valid), 64'd0);
    ready = 1'b0;
    flip(37);
    tick();
    chk("R3 record", 64'(evt_valid), 64'd1);
    chk("R3 masked bit reads 0", 64'(evt_curr[4]), 64'd0);
    chk("R3 xor", 64'(evt_prev ^ evt_curr), 64'h20);
    drain();
    mask[36] = 1'b1;
    drain();

    // R7: capture disabled
    cap_en = 1'b0;
    flip(40);
    repeat (3) tick();
    chk("R7 no record while off", 64'(evt_valid), 64'd0);
    ready = 1'b0;
    cap_en = 1'b1;
    tick();
    chk("R7 record on resume", 64'(evt_valid), 64'd1);
    chk("R7 xor", 64'(evt_prev ^ evt_curr), 64'h100);
    drain();

    // R11: change on the acceptance edge re-arms
    ready = 1'b1;
    flip(1);
    tick();
    chk("R11 first record", 64'(evt_valid), 64'd1);
    flip(2);
    tick();
    chk("R11 re-armed", 64'(evt_valid), 64'd1);
    chk("R11 xor", 64'(evt_prev ^ evt_curr), 64'h4);
    chk("R11 no ovf", 64'(ovf), 64'd0);
    tick();
    chk("R11 drained", 64'(evt_valid), 64'd0);
    drain();

    // R2: detections 16 edges apart
    flip(10);
    tick();
    ta = evt_ts;
    repeat (15) tick();
    flip(11);
    tick();
    chk("R2 ts step", evt_ts - ta, 64'd4);
    drain();

    // R10: second change while pending
    ready = 1'b0;
    flip(64);
    tick(); tick();
    chk("R10 no ovf yet", 64'(ovf), 64'd0);
    flip(65);
    tick();
    chk("R10 ovf set", 64'(ovf), 64'd1);
    chk("R10 first capture kept", 64'(evt_curr[1]), 64'd0);
    drain();
    chk("R10 ovf sticky", 64'(ovf), 64'd1);

    // reset again
    rst_n = 1'b0;
    tick(); tick();
    chk("R1 valid after reset", 64'(evt_valid), 64'd0);
    chk("R1 ovf after reset", 64'(ovf), 64'd0);
    rst_n = 1'b1;
    tick();

    // random phase
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 3 == 0) flip(int'($urandom % BW));
      if ($urandom % 7 == 0) flip(int'($urandom % BW));
      if ($urandom % 500 == 0) mask = {$urandom, $urandom, $urandom} | {$urandom, $urandom, $urandom};
      ready = ($urandom % 4) != 0;
      if ($urandom % 300 == 0) cap_en = ~cap_en;
      tick();
    end

    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
    $finish;
  end
endmodule